// File: doc/BRIEF.md
# Hsync-Deferred Video Mode Latch

This block holds the active video mode of a bitmap display and the pixel clock divider that goes with it. A CPU write of a requested mode does not act at once. The requested value is kept in a staging register. It moves into the active mode only at one fixed point inside horizontal sync, so that a mode change never splits a visible line.

The transfer happens on the enabled cycle in which hsync has already been high for `LATCH_POINT` consecutive enabled cycles and is still high. It happens only if the staged value differs from the active one. Whenever the active mode changes, a one-cycle pulse tells downstream logic, such as palette or pixel decode tables, to rebuild. All state advances only on cycles where the per-cycle enable is high.

Top module: `vmode_latch`

## Requirements
- R1: After reset the active mode is 0, the divider output is 4 and the change pulse is low.
- R2: The divider output follows the active mode: mode 0 gives 4, mode 1 gives 2, mode 2 gives 1, and mode 3 gives 4.
- R3: A mode write (`wr_i` high with `en_i` high) only updates the staged value. The active mode does not change outside the latch point.
- R4: On the enabled cycle in which `hsync_i` is high and the previous `LATCH_POINT` enabled cycles also had `hsync_i` high, the staged mode becomes the active mode, visible after that clock edge.
- R5: If hsync falls before that latch point is reached, no mode change happens on that line.
- R6: The latch point is reached at most once per hsync pulse. The in-hsync count saturates, and a write made after the latch point of a long pulse waits for the next pulse.
- R7: `mode_chg_o` is high for exactly one cycle, the cycle after the active mode changes. It stays low when the staged mode equals the active mode at the latch point.
- R8: A write in the same cycle as the latch point is not applied at that point. The previously staged value is used, and the new value is applied at the next hsync.
- R9: While `en_i` is low, the in-hsync count, the staged mode and the active mode all hold, and writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Per-cycle enable; state advances only when high |
| wr_i | input | 1 | Mode write strobe |
| wr_mode_i | input | 2 | Requested mode value |
| hsync_i | input | 1 | Horizontal sync level, active high |
| mode_o | output | 2 | Active video mode |
| div_o | output | 3 | Pixel clock divider for the active mode |
| mode_chg_o | output | 1 | One-cycle pulse after the active mode changes |

## Verification
The bench builds the block with `LATCH_POINT` = 4. At that value, every hsync pulse length from 1 to 12 cycles can be swept cheaply: pulses that end just before the latch point, one that hits it exactly, and pulses that run well past it.

With 2-bit modes, all sixteen ordered pairs of old and new mode can be covered. That includes the four pairs with no change, where the pulse must stay low. Writes placed at, before and after the latch point, and stretches with the enable held low in the middle of hsync, are compared cycle by cycle against expected values computed in the bench.

// File: rtl/vml_pkg.sv
package vml_pkg;
  localparam int unsigned MODE_W = 2;
  localparam int unsigned DIV_W  = 3;
  typedef logic [MODE_W-1:0] mode_t;
  typedef logic [DIV_W-1:0]  div_t;
endpackage

// File: rtl/vml_hs_counter.sv
module vml_hs_counter #(
  parameter int unsigned LATCH_POINT = 4,
  localparam int unsigned CNT_W = $clog2(LATCH_POINT + 2)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic hsync_i,
  output logic at_point_o
);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(LATCH_POINT + 1);
  localparam logic [CNT_W-1:0] HIT = CNT_W'(LATCH_POINT);

  logic [CNT_W-1:0] cnt_q;

  // counts enabled hsync-high cycles; saturating so the point fires once per pulse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (en_i) begin
      if (!hsync_i)        cnt_q <= '0;
      else if (cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign at_point_o = en_i && hsync_i && (cnt_q == HIT);
endmodule

// File: rtl/vml_mode_regs.sv
module vml_mode_regs
  import vml_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  logic  wr_i,
  input  mode_t wr_mode_i,
  input  logic  at_point_i,
  output mode_t mode_o,
  output logic  chg_o
);
  mode_t stg_q, act_q;
  logic  chg_q, fire;

  assign fire = at_point_i && (stg_q != act_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
      act_q <= '0;
      chg_q <= 1'b0;
    end else begin
      if (en_i && wr_i) stg_q <= wr_mode_i;
      if (fire)         act_q <= stg_q;  // old staged value wins over a same-cycle write
      chg_q <= fire;
    end
  end

  assign mode_o = act_q;
  assign chg_o  = chg_q;
endmodule

// File: rtl/vml_div_decode.sv
module vml_div_decode
  import vml_pkg::*;
(
  input  mode_t mode_i,
  output div_t  div_o
);
  always_comb begin
    unique case (mode_i)
      2'd1:    div_o = DIV_W'(2);
      2'd2:    div_o = DIV_W'(1);
      default: div_o = DIV_W'(4);
    endcase
  end
endmodule

// File: rtl/vmode_latch.sv
module vmode_latch
  import vml_pkg::*;
#(
  parameter int unsigned LATCH_POINT = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       wr_i,
  input  logic [1:0] wr_mode_i,
  input  logic       hsync_i,
  output logic [1:0] mode_o,
  output logic [2:0] div_o,
  output logic       mode_chg_o
);
  logic  at_point;
  mode_t mode_act;

  vml_hs_counter #(.LATCH_POINT(LATCH_POINT)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .hsync_i    (hsync_i),
    .at_point_o (at_point)
  );

  vml_mode_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .wr_i       (wr_i),
    .wr_mode_i  (wr_mode_i),
    .at_point_i (at_point),
    .mode_o     (mode_act),
    .chg_o      (mode_chg_o)
  );

  vml_div_decode u_dec (
    .mode_i (mode_act),
    .div_o  (div_o)
  );

  assign mode_o = mode_act;
endmodule

// File: rtl/vmode_latch_chk.sv
module vmode_latch_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic       hsync_i,
  input logic [1:0] mode_o,
  input logic [2:0] div_o,
  input logic       mode_chg_o
);
  // R2
  div_m0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd0 || mode_o == 2'd3) |-> div_o == 3'd4);
  // R2
  div_m1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd1) |-> div_o == 3'd2);
  // R2
  div_m2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd2) |-> div_o == 3'd1);
  // R3
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_chg_o |-> $stable(mode_o));
  // R7
  chg_real_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg_o |-> mode_o != $past(mode_o));
  // R7
  chg_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg_o |=> !mode_chg_o);
  // R5
  chg_in_hsync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg_o |-> $past(hsync_i) && $past(en_i));
  // R9
  en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !mode_chg_o);
endmodule

bind vmode_latch vmode_latch_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .hsync_i    (hsync_i),
  .mode_o     (mode_o),
  .div_o      (div_o),
  .mode_chg_o (mode_chg_o)
);

// File: tb/sim_vmode_latch.sv
`timescale 1ns/1ps
module sim_vmode_latch;
  localparam int LP = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, wr = 1'b0, hs = 1'b0;
  logic [1:0] wm = 2'd0;
  logic [1:0] mode;
  logic [2:0] div;
  logic       chg;

  int checks = 0, errors = 0;
  int m_stg = 0, m_act = 0, m_cnt = 0;
  bit m_chg = 1'b0;

  always #2 clk = ~clk;

  vmode_latch #(.LATCH_POINT(LP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .wr_i(wr), .wr_mode_i(wm),
    .hsync_i(hs), .mode_o(mode), .div_o(div), .mode_chg_o(chg)
  );

  function automatic int exp_div(int m);
    return (m > 2) ? 4 : (4 >> m);
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, "mode", int'(mode), m_act);
    chk("R2", "div", int'(div), exp_div(m_act));
    chk(tag, "chg", int'(chg), int'(m_chg));
  endtask

  task automatic step(bit e, bit w, int v, bit h, string tag);
    bit fire;
    @(negedge clk);
    en = e; wr = w; wm = 2'(v); hs = h;
    @(posedge clk);
    fire = e && h && (m_cnt == LP) && (m_stg != m_act);
    m_chg = fire;
    if (fire) m_act = m_stg;
    if (e && w) m_stg = v;
    if (e) m_cnt = !h ? 0 : (m_cnt <= LP ? m_cnt + 1 : m_cnt);
    #1 check_all(tag);
  endtask

  task automatic pulse(int len, string tag);
    for (int i = 0; i < len; i++) step(1, 0, 0, 1, tag);
    step(1, 0, 0, 0, tag);
    step(1, 0, 0, 0, tag);
  endtask

  task automatic wr_mode(int v, string tag);
    step(1, 1, v, 0, tag);
  endtask

  initial begin
    #(4 * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #7 rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1", "mode", int'(mode), 0);
    chk("R1", "div", int'(div), 4);
    chk("R1", "chg", int'(chg), 0);

    // R3 writes without hsync never move the active mode
    for (int v = 0; v < 4; v++) begin
      wr_mode(v, "R3");
      step(1, 0, 0, 0, "R3");
    end

    // R4 R7 all ordered mode pairs
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++) begin
        wr_mode(a, "R4"); pulse(LP + 2, "R4");
        wr_mode(b, "R7"); pulse(LP + 2, "R7");
      end

    // R5 pulse lengths up to and past the latch point
    for (int len = 1; len <= 3 * LP; len++) begin
      wr_mode((m_act + 1) % 4, "R5");
      pulse(len, len <= LP ? "R5" : "R4");
    end

    // R6 write after latch point of a long pulse waits for next pulse
    wr_mode(1, "R6"); pulse(LP + 2, "R6");
    for (int i = 0; i < LP + 1; i++) step(1, 0, 0, 1, "R6");
    step(1, 1, 2, 1, "R6");
    for (int i = 0; i < 2 * LP; i++) step(1, 0, 0, 1, "R6");
    step(1, 0, 0, 0, "R6");
    chk("R6", "mode held", int'(mode), 1);
    pulse(LP + 1, "R6");
    chk("R6", "mode applied", int'(mode), 2);

    // R8 write in the latch-point cycle
    wr_mode(0, "R8");
    for (int i = 0; i < LP; i++) step(1, 0, 0, 1, "R8");
    step(1, 1, 3, 1, "R8");
    step(1, 0, 0, 0, "R8");
    chk("R8", "old staged used", int'(mode), 0);
    pulse(LP + 1, "R8");
    chk("R8", "new applied later", int'(mode), 3);

    // R9 enable low freezes counting and ignores writes
    wr_mode(1, "R9");
    for (int i = 0; i < LP - 1; i++) step(1, 0, 0, 1, "R9");
    for (int i = 0; i < 3 * LP; i++) step(0, (i % 2) == 1, 2, 1, "R9");
    chk("R9", "frozen", int'(mode), 3);
    step(1, 0, 0, 1, "R9");
    step(1, 0, 0, 1, "R9");
    chk("R9", "resumed", int'(mode), 1);
    for (int i = 0; i < 4; i++) step(0, 1, 0, 0, "R9");
    pulse(LP + 2, "R9");
    chk("R9", "write ignored", int'(mode), 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule